// File: doc/BRIEF.md
# Exception entry and return controller

This block owns the control-state side of exceptions in a small processor core. When one or more exception requests arrive, it picks the winner, works out the return link from the trapping PC and the current execution state, and writes that link and the old status word into the banks of the target mode. In the same cycle it switches the mode, raises the interrupt masks and sends fetch to the vector of that exception.

It also carries out three status operations. The first is a change-processor-state operation that writes the masks, the mode or both. The second is a subtract-and-return that sends the PC back to the banked link minus 0, 4 or 8 and restores the saved status. The third is a return-from-exception that reads a PC word and a status word from two consecutive addresses through a read port with a ready handshake, then applies both at once.

The banked link and saved-status registers of the current mode are visible at the ports. The general register file and instruction decode sit outside the block.

Top module: `exc_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `psr_o` is 0x000000D3: supervisor mode 10011, I mask at bit 7 set, F mask at bit 6 set. `redir_valid` is 1 with `redir_pc` = `vec_base`, and `mem_req` is 0. The supervisor link and saved status are not defined until the first entry to that mode.
- R2: Requests that arrive together are served in this order: data abort, FIQ, IRQ, prefetch abort, undefined, supervisor call, monitor call, breakpoint. Only the winner is taken.
- R3: An IRQ request is ignored while I (bit 7) is set. An FIQ request is ignored while F (bit 6) is set.
- R4: On supervisor-call and undefined entry, the saved link is `cur_pc`+2 when `xstate` is 01 (16-bit compressed) and `cur_pc`+4 otherwise. `xstate` 00 is 32-bit, 10 is bytecode, and 11 behaves as 00.
- R5: On prefetch abort, IRQ, FIQ, breakpoint and monitor-call entry, the saved link is `cur_pc`+4 in every state. On data abort it is `cur_pc`+8.
- R6: Entry sets these modes: supervisor call to 10011, undefined to 11011, either abort or breakpoint to 10111, IRQ to 10010, FIQ to 10001, monitor call to 10110. The mode's saved status receives the old `psr_o`. I is set on every entry and F is also set on FIQ entry. Bit 5 and bits 31:8 are kept.
- R7: One cycle after the request is taken, `redir_valid` pulses with `vec_base` plus an offset: 0x04 undefined, 0x08 supervisor call, 0x0C prefetch abort or breakpoint, 0x10 data abort, 0x18 IRQ, 0x1C FIQ. Monitor-call entry goes to `mon_vec` instead.
- R8: A monitor-call request is ignored unless `xstate` is 32-bit. A supervisor-call request is ignored in bytecode state.
- R9: `ret_go` redirects to the current mode's link minus 0, 4, 8 or 0 for `ret_sel` 00, 01, 10 or 11, and copies that mode's saved status into `psr_o`. The operation has no effect in user (10000) or system (11111) mode.
- R10: `cps_go` writes I and F from `cps_irq_m` and `cps_fiq_m` when `cps_mask_wr` is set, and writes the mode from `cps_mode` when `cps_mode_wr` is set. The operation has no effect in user mode and does not redirect.
- R11: When `xstate` is 01, the mode write of `cps_go` is ignored and the mask write still applies.
- R12: `rfe_go` reads `rfe_base` and then `rfe_base`+4. Each beat holds `mem_req` and `mem_addr` until `mem_ready`. The first word becomes the PC and the second becomes `psr_o`. Both are applied in the cycle after the second beat is accepted, and nothing changes before that.
- R13: An exception outranks every operation and cancels a return-from-exception in flight. Operations are ignored while one is in flight. Among operations that arrive together, `ret_go` beats `cps_go`, which beats `rfe_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, taken as the reset exception |
| vec_base | input | 32 | Base address of the vector table |
| mon_vec | input | 32 | Vector for monitor-call entry |
| xstate | input | 2 | Execution state: 00 32-bit, 01 compressed, 10 bytecode |
| cur_pc | input | 32 | Address of the trapping or interrupted instruction |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Undefined instruction request |
| req_svc | input | 1 | Supervisor call request |
| req_smc | input | 1 | Secure monitor call request |
| req_bkpt | input | 1 | Software breakpoint request |
| ret_go | input | 1 | Start a subtract-and-return |
| ret_sel | input | 2 | Return adjustment select |
| cps_go | input | 1 | Start a change-processor-state operation |
| cps_mask_wr | input | 1 | Write the I and F masks |
| cps_irq_m | input | 1 | New I mask |
| cps_fiq_m | input | 1 | New F mask |
| cps_mode_wr | input | 1 | Write the mode |
| cps_mode | input | 5 | New mode |
| rfe_go | input | 1 | Start a return-from-exception |
| rfe_base | input | 32 | Address of the saved PC word |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read address |
| mem_ready | input | 1 | Read beat accepted, data valid |
| mem_rdata | input | 32 | Read data |
| psr_o | output | 32 | Current status word |
| link_o | output | 32 | Banked link of the current mode, 0 in user or system mode |
| spsr_o | output | 32 | Saved status of the current mode, 0 in user or system mode |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_pc | output | 32 | Fetch redirect target |

## Verification
Directed cases exercise one behaviour each. Raising all requests at once tells the priority order apart from a plain OR of the requests. A trap taken in each execution state separates the +2 and +4 links. Returns with each adjustment after entries of different kinds show whether the right bank is read. A compressed-state status change with both writes enabled separates the mask path from the mode path, and return-from-exception with stalled beats and an abort in the middle shows whether the update is atomic. Seeded random traffic then mixes states, requests, masks, operations and read stalls. Every cycle is compared against a model built from the requirements, which also catches wrong interplay between an operation in flight and an exception.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN    = 32;
    localparam int MODE_W  = 5;
    localparam int NBANK   = 6;
    localparam int BANK_W  = $clog2(NBANK);
    localparam int OFF_W   = 4;
    localparam int VOFF_W  = 8;
    localparam int WORD_B  = 4;

    typedef enum logic [MODE_W-1:0] {
        M_USR = 5'b10000,
        M_FIQ = 5'b10001,
        M_IRQ = 5'b10010,
        M_SVC = 5'b10011,
        M_MON = 5'b10110,
        M_ABT = 5'b10111,
        M_UND = 5'b11011,
        M_SYS = 5'b11111
    } mode_e;

    typedef enum logic [1:0] {
        XS_WORD = 2'd0,
        XS_HALF = 2'd1,
        XS_BYTE = 2'd2,
        XS_RSVD = 2'd3
    } xstate_e;

    typedef enum logic [3:0] {
        EX_NONE, EX_DABT, EX_FIQ, EX_IRQ, EX_PABT,
        EX_UND, EX_SVC, EX_SMC, EX_BKPT
    } exc_e;

    typedef struct packed {
        logic [XLEN-9:0]   upper;
        logic              irq_m;
        logic              fiq_m;
        logic              tbit;
        logic [MODE_W-1:0] mode;
    } psr_t;

    typedef struct packed {
        logic              ok;
        logic [BANK_W-1:0] idx;
    } bank_sel_t;

    localparam psr_t PSR_RESET = '{upper: '0, irq_m: 1'b1, fiq_m: 1'b1,
                                   tbit: 1'b0, mode: M_SVC};

    function automatic logic [MODE_W-1:0] exc_mode(exc_e k);
        case (k)
            EX_SVC:                    return M_SVC;
            EX_UND:                    return M_UND;
            EX_DABT, EX_PABT, EX_BKPT: return M_ABT;
            EX_IRQ:                    return M_IRQ;
            EX_FIQ:                    return M_FIQ;
            EX_SMC:                    return M_MON;
            default:                   return M_SVC;
        endcase
    endfunction

    function automatic logic [OFF_W-1:0] link_off(exc_e k, logic [1:0] xs);
        case (k)
            EX_DABT:        return OFF_W'(8);
            EX_SVC, EX_UND: return (xs == XS_HALF) ? OFF_W'(2) : OFF_W'(4);
            default:        return OFF_W'(4);
        endcase
    endfunction

    function automatic logic [VOFF_W-1:0] vec_off(exc_e k);
        case (k)
            EX_UND:           return 8'h04;
            EX_SVC:           return 8'h08;
            EX_PABT, EX_BKPT: return 8'h0C;
            EX_DABT:          return 8'h10;
            EX_IRQ:           return 8'h18;
            EX_FIQ:           return 8'h1C;
            default:          return 8'h00;
        endcase
    endfunction

    function automatic bank_sel_t bank_of(logic [MODE_W-1:0] m);
        case (m)
            M_SVC:   return '{ok: 1'b1, idx: BANK_W'(0)};
            M_ABT:   return '{ok: 1'b1, idx: BANK_W'(1)};
            M_UND:   return '{ok: 1'b1, idx: BANK_W'(2)};
            M_IRQ:   return '{ok: 1'b1, idx: BANK_W'(3)};
            M_FIQ:   return '{ok: 1'b1, idx: BANK_W'(4)};
            M_MON:   return '{ok: 1'b1, idx: BANK_W'(5)};
            default: return '{ok: 1'b0, idx: '0};
        endcase
    endfunction

    function automatic logic [OFF_W-1:0] ret_amount(logic [1:0] sel);
        case (sel)
            2'b01:   return OFF_W'(4);
            2'b10:   return OFF_W'(8);
            default: return OFF_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic       req_dabt,
    input  logic       req_fiq,
    input  logic       req_irq,
    input  logic       req_pabt,
    input  logic       req_und,
    input  logic       req_svc,
    input  logic       req_smc,
    input  logic       req_bkpt,
    input  logic       mask_i,
    input  logic       mask_f,
    input  logic [1:0] xstate,
    output logic       take,
    output exc_e       kind
);
    logic smc_ok;
    logic svc_ok;

    always_comb begin
        smc_ok = req_smc && (xstate == XS_WORD || xstate == XS_RSVD);
        svc_ok = req_svc && (xstate != XS_BYTE);
        if (req_dabt)                kind = EX_DABT;
        else if (req_fiq && !mask_f) kind = EX_FIQ;
        else if (req_irq && !mask_i) kind = EX_IRQ;
        else if (req_pabt)           kind = EX_PABT;
        else if (req_und)            kind = EX_UND;
        else if (svc_ok)             kind = EX_SVC;
        else if (smc_ok)             kind = EX_SMC;
        else if (req_bkpt)           kind = EX_BKPT;
        else                         kind = EX_NONE;
        take = (kind != EX_NONE);
    end
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
    import exc_pkg::*;
(
    input  exc_e              kind,
    input  logic [1:0]        xstate,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   vec_base,
    input  logic [XLEN-1:0]   mon_vec,
    output logic [XLEN-1:0]   link,
    output logic [MODE_W-1:0] mode,
    output logic [XLEN-1:0]   vector,
    output bank_sel_t         bank
);
    always_comb begin
        link   = cur_pc + XLEN'(link_off(kind, xstate));
        mode   = exc_mode(kind);
        vector = (kind == EX_SMC) ? mon_vec : (vec_base + XLEN'(vec_off(kind)));
        bank   = bank_of(mode);
    end
endmodule

// File: rtl/exc_rfe_seq.sv
module exc_rfe_seq
    import exc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [XLEN-1:0] base,
    input  logic            cancel,
    input  logic            mem_ready,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_addr,
    output logic            busy,
    output logic            commit,
    output logic [XLEN-1:0] commit_pc,
    output logic [XLEN-1:0] commit_psr
);
    typedef enum logic [1:0] {RS_IDLE, RS_LO, RS_HI} rfe_st_e;

    rfe_st_e         st_q;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            st_q <= RS_IDLE;
        end else begin
            case (st_q)
                RS_IDLE: if (start) begin
                    st_q   <= RS_LO;
                    addr_q <= base;
                end
                RS_LO: if (mem_ready) begin
                    st_q   <= RS_HI;
                    pc_q   <= mem_rdata;
                    addr_q <= addr_q + XLEN'(WORD_B);
                end
                RS_HI: if (mem_ready) st_q <= RS_IDLE;
                default: st_q <= RS_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (st_q != RS_IDLE);
        mem_req    = busy;
        mem_addr   = addr_q;
        commit     = (st_q == RS_HI) && mem_ready && !cancel;
        commit_pc  = pc_q;
        commit_psr = mem_rdata;
    end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   vec_base,
    input  logic [XLEN-1:0]   mon_vec,
    input  logic [1:0]        xstate,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              req_dabt,
    input  logic              req_fiq,
    input  logic              req_irq,
    input  logic              req_pabt,
    input  logic              req_und,
    input  logic              req_svc,
    input  logic              req_smc,
    input  logic              req_bkpt,
    input  logic              ret_go,
    input  logic [1:0]        ret_sel,
    input  logic              cps_go,
    input  logic              cps_mask_wr,
    input  logic              cps_irq_m,
    input  logic              cps_fiq_m,
    input  logic              cps_mode_wr,
    input  logic [MODE_W-1:0] cps_mode,
    input  logic              rfe_go,
    input  logic [XLEN-1:0]   rfe_base,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    input  logic              mem_ready,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic [XLEN-1:0]   psr_o,
    output logic [XLEN-1:0]   link_o,
    output logic [XLEN-1:0]   spsr_o,
    output logic              redir_valid,
    output logic [XLEN-1:0]   redir_pc
);
    psr_t              psr_q;
    logic              redir_v_q;
    logic [XLEN-1:0]   redir_pc_q;
    logic [XLEN-1:0]   link_q [NBANK];
    psr_t              spsr_q [NBANK];

    logic              exc_take;
    exc_e              exc_kind;
    logic [XLEN-1:0]   ent_link;
    logic [MODE_W-1:0] ent_mode;
    logic [XLEN-1:0]   ent_vec;
    bank_sel_t         ent_bank;
    bank_sel_t         cur_bank;

    logic              rfe_start;
    logic              rfe_busy;
    logic              rfe_commit;
    logic [XLEN-1:0]   rfe_pc;
    logic [XLEN-1:0]   rfe_psr;

    exc_arbiter u_arb (
        .req_dabt (req_dabt),
        .req_fiq  (req_fiq),
        .req_irq  (req_irq),
        .req_pabt (req_pabt),
        .req_und  (req_und),
        .req_svc  (req_svc),
        .req_smc  (req_smc),
        .req_bkpt (req_bkpt),
        .mask_i   (psr_q.irq_m),
        .mask_f   (psr_q.fiq_m),
        .xstate   (xstate),
        .take     (exc_take),
        .kind     (exc_kind)
    );

    exc_entry_calc u_calc (
        .kind     (exc_kind),
        .xstate   (xstate),
        .cur_pc   (cur_pc),
        .vec_base (vec_base),
        .mon_vec  (mon_vec),
        .link     (ent_link),
        .mode     (ent_mode),
        .vector   (ent_vec),
        .bank     (ent_bank)
    );

    assign rfe_start = rfe_go && !rfe_busy && !exc_take && !ret_go && !cps_go;

    exc_rfe_seq u_rfe (
        .clk        (clk),
        .rst        (rst),
        .start      (rfe_start),
        .base       (rfe_base),
        .cancel     (exc_take),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .busy       (rfe_busy),
        .commit     (rfe_commit),
        .commit_pc  (rfe_pc),
        .commit_psr (rfe_psr)
    );

    assign cur_bank = bank_of(psr_q.mode);

    always_ff @(posedge clk) begin
        redir_v_q <= 1'b0;
        if (rst) begin
            psr_q      <= PSR_RESET;
            redir_v_q  <= 1'b1;
            redir_pc_q <= vec_base;
        end else if (exc_take) begin
            psr_q.mode  <= ent_mode;
            psr_q.irq_m <= 1'b1;
            if (exc_kind == EX_FIQ) psr_q.fiq_m <= 1'b1;
            redir_v_q   <= 1'b1;
            redir_pc_q  <= ent_vec;
        end else if (rfe_commit) begin
            psr_q      <= psr_t'(rfe_psr);
            redir_v_q  <= 1'b1;
            redir_pc_q <= rfe_pc;
        end else if (!rfe_busy) begin
            if (ret_go) begin
                if (cur_bank.ok) begin
                    psr_q      <= spsr_q[cur_bank.idx];
                    redir_v_q  <= 1'b1;
                    redir_pc_q <= link_q[cur_bank.idx] - XLEN'(ret_amount(ret_sel));
                end
            end else if (cps_go && psr_q.mode != M_USR) begin
                if (cps_mask_wr) begin
                    psr_q.irq_m <= cps_irq_m;
                    psr_q.fiq_m <= cps_fiq_m;
                end
                if (cps_mode_wr && xstate != XS_HALF) psr_q.mode <= cps_mode;
            end
        end
    end

    // Banked storage has no reset: contents are undefined until first entry.
    always_ff @(posedge clk) begin
        if (!rst && exc_take && ent_bank.ok) begin
            link_q[ent_bank.idx] <= ent_link;
            spsr_q[ent_bank.idx] <= psr_q;
        end
    end

    always_comb begin
        psr_o       = psr_q;
        link_o      = cur_bank.ok ? link_q[cur_bank.idx] : '0;
        spsr_o      = cur_bank.ok ? spsr_q[cur_bank.idx] : '0;
        redir_valid = redir_v_q;
        redir_pc    = redir_pc_q;
    end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk
    import exc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            take,
    input exc_e            kind,
    input logic [XLEN-1:0] psr,
    input logic [1:0]      xstate,
    input logic            cps_go,
    input logic            ret_go,
    input logic            busy,
    input logic            mem_req,
    input logic            mem_ready,
    input logic [XLEN-1:0] mem_addr,
    input logic            redir_valid
);
    p_entry_sets_i_r6: assert property (@(posedge clk) disable iff (rst)
        take |=> psr[7]);

    p_fiq_sets_f_r6: assert property (@(posedge clk) disable iff (rst)
        (take && kind == EX_FIQ) |=> psr[6]);

    p_irq_unmasked_r3: assert property (@(posedge clk) disable iff (rst)
        (take && kind == EX_IRQ) |-> !psr[7]);

    p_fiq_unmasked_r3: assert property (@(posedge clk) disable iff (rst)
        (take && kind == EX_FIQ) |-> !psr[6]);

    p_entry_redirect_r7: assert property (@(posedge clk) disable iff (rst)
        take |=> redir_valid);

    p_beat_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready && !take) |=> (mem_req && $stable(mem_addr)));

    p_half_mode_kept_r11: assert property (@(posedge clk) disable iff (rst)
        (cps_go && xstate == XS_HALF && !take && !busy && !ret_go)
        |=> $stable(psr[4:0]));
endmodule

bind exc_ctrl exc_ctrl_chk u_exc_ctrl_chk (
    .clk         (clk),
    .rst         (rst),
    .take        (exc_take),
    .kind        (exc_kind),
    .psr         (psr_o),
    .xstate      (xstate),
    .cps_go      (cps_go),
    .ret_go      (ret_go),
    .busy        (rfe_busy),
    .mem_req     (mem_req),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .redir_valid (redir_valid)
);

// File: tb/test_exc_ctrl.sv
module test_exc_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] vec_base = 32'hFFFF_0000;
    logic [31:0] mon_vec  = 32'h0000_4000;
    logic [1:0]  xstate;
    logic [31:0] cur_pc;
    logic        req_dabt, req_fiq, req_irq, req_pabt, req_und, req_svc, req_smc, req_bkpt;
    logic        ret_go;
    logic [1:0]  ret_sel;
    logic        cps_go, cps_mask_wr, cps_irq_m, cps_fiq_m, cps_mode_wr;
    logic [4:0]  cps_mode;
    logic        rfe_go;
    logic [31:0] rfe_base;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ready;
    logic [31:0] mem_rdata;
    logic [31:0] psr_o, link_o, spsr_o, redir_pc;
    logic        redir_valid;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_psr;
    logic [31:0] m_link [6];
    logic [31:0] m_spsr [6];
    bit          m_known [6];
    logic        m_rv;
    logic [31:0] m_rpc;
    int          m_st;
    logic [31:0] m_addr;
    logic [31:0] m_pcq;

    always #4 clk = ~clk;

    exc_ctrl i_exc_ctrl (
        .clk(clk), .rst(rst), .vec_base(vec_base), .mon_vec(mon_vec),
        .xstate(xstate), .cur_pc(cur_pc),
        .req_dabt(req_dabt), .req_fiq(req_fiq), .req_irq(req_irq), .req_pabt(req_pabt),
        .req_und(req_und), .req_svc(req_svc), .req_smc(req_smc), .req_bkpt(req_bkpt),
        .ret_go(ret_go), .ret_sel(ret_sel),
        .cps_go(cps_go), .cps_mask_wr(cps_mask_wr), .cps_irq_m(cps_irq_m),
        .cps_fiq_m(cps_fiq_m), .cps_mode_wr(cps_mode_wr), .cps_mode(cps_mode),
        .rfe_go(rfe_go), .rfe_base(rfe_base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .psr_o(psr_o), .link_o(link_o), .spsr_o(spsr_o),
        .redir_valid(redir_valid), .redir_pc(redir_pc)
    );

    function automatic logic [4:0] mode_at(int i);
        case (i)
            0: return 5'b10000;
            1: return 5'b10001;
            2: return 5'b10010;
            3: return 5'b10011;
            4: return 5'b10111;
            5: return 5'b11011;
            6: return 5'b11111;
            default: return 5'b10110;
        endcase
    endfunction

    function automatic int bidx(logic [4:0] m);
        case (m)
            5'b10011: return 0;
            5'b10111: return 1;
            5'b11011: return 2;
            5'b10010: return 3;
            5'b10001: return 4;
            5'b10110: return 5;
            default:  return -1;
        endcase
    endfunction

    function automatic logic [31:0] mem_fn(logic [31:0] a);
        return {a[31:8] ^ 24'hA5C3E1, a[3], a[4], a[2], mode_at(int'(a[7:5]))};
    endfunction

    task automatic clear_ins();
        xstate = 2'd0; cur_pc = 32'h0000_1000;
        {req_dabt, req_fiq, req_irq, req_pabt, req_und, req_svc, req_smc, req_bkpt} = '0;
        ret_go = 0; ret_sel = 0; cps_go = 0; cps_mask_wr = 0; cps_irq_m = 0;
        cps_fiq_m = 0; cps_mode_wr = 0; cps_mode = 5'b10011; rfe_go = 0;
        rfe_base = 32'h0000_2000; mem_ready = 0;
    endtask

    task automatic model_step();
        bit take;
        logic [4:0] nm;
        logic [31:0] vec;
        logic [3:0] off;
        bit busy;
        int b;
        take = 1; off = 4; nm = 5'b10011; vec = 0;
        if (rst) begin
            m_psr = 32'h0000_00D3; m_rv = 1; m_rpc = vec_base; m_st = 0;
            return;
        end
        m_rv = 0;
        busy = (m_st != 0);
        if (req_dabt) begin nm = 5'b10111; vec = vec_base + 32'h10; off = 8; end
        else if (req_fiq && !m_psr[6]) begin nm = 5'b10001; vec = vec_base + 32'h1C; end
        else if (req_irq && !m_psr[7]) begin nm = 5'b10010; vec = vec_base + 32'h18; end
        else if (req_pabt) begin nm = 5'b10111; vec = vec_base + 32'h0C; end
        else if (req_und) begin nm = 5'b11011; vec = vec_base + 32'h04; off = (xstate == 1) ? 2 : 4; end
        else if (req_svc && xstate != 2) begin nm = 5'b10011; vec = vec_base + 32'h08; off = (xstate == 1) ? 2 : 4; end
        else if (req_smc && (xstate == 0 || xstate == 3)) begin nm = 5'b10110; vec = mon_vec; end
        else if (req_bkpt) begin nm = 5'b10111; vec = vec_base + 32'h0C; end
        else take = 0;

        if (take) begin
            b = bidx(nm);
            m_link[b] = cur_pc + 32'(off);
            m_spsr[b] = m_psr;
            m_known[b] = 1;
            m_psr[4:0] = nm;
            m_psr[7] = 1;
            if (nm == 5'b10001) m_psr[6] = 1;
            m_rv = 1; m_rpc = vec; m_st = 0;
        end else if (m_st == 2 && mem_ready) begin
            m_psr = mem_rdata; m_rv = 1; m_rpc = m_pcq; m_st = 0;
        end else begin
            if (m_st == 1 && mem_ready) begin
                m_pcq = mem_rdata; m_addr = m_addr + 4; m_st = 2;
            end
            if (!busy) begin
                if (ret_go) begin
                    b = bidx(m_psr[4:0]);
                    if (b >= 0) begin
                        m_rv = 1;
                        m_rpc = m_link[b] - ((ret_sel == 1) ? 32'd4 : (ret_sel == 2) ? 32'd8 : 32'd0);
                        m_psr = m_spsr[b];
                    end
                end else if (cps_go) begin
                    if (m_psr[4:0] != 5'b10000) begin
                        if (cps_mask_wr) begin m_psr[7] = cps_irq_m; m_psr[6] = cps_fiq_m; end
                        if (cps_mode_wr && xstate != 1) m_psr[4:0] = cps_mode;
                    end
                end else if (rfe_go) begin
                    m_st = 1; m_addr = rfe_base;
                end
            end
        end
    endtask

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        int b;
        check(tag, "psr_o", psr_o, m_psr);
        check(tag, "redir_valid", 32'(redir_valid), 32'(m_rv));
        if (m_rv) check(tag, "redir_pc", redir_pc, m_rpc);
        check(tag, "mem_req", 32'(mem_req), 32'(m_st != 0));
        if (m_st != 0) check(tag, "mem_addr", mem_addr, m_addr);
        b = bidx(m_psr[4:0]);
        if (b < 0) begin
            check(tag, "link_o", link_o, 32'h0);
            check(tag, "spsr_o", spsr_o, 32'h0);
        end else if (m_known[b]) begin
            check(tag, "link_o", link_o, m_link[b]);
            check(tag, "spsr_o", spsr_o, m_spsr[b]);
        end
    endtask

    task automatic cycle(string tag);
        mem_rdata = mem_fn(m_addr);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 6; i++) m_known[i] = 0;
        m_addr = 0; m_pcq = 0; m_st = 0;
        clear_ins();
        rst = 1;
        @(negedge clk);
        cycle("R1");
        cycle("R1");
        rst = 0;
        // R1: explicit reset value, first cycle after release
        check("R1", "psr_o reset", psr_o, 32'h0000_00D3);
        check("R1", "redir_pc reset", redir_pc, 32'hFFFF_0000);
        // R3: both interrupts masked after reset
        req_irq = 1; req_fiq = 1; cycle("R3");
        clear_ins();
        // R10: clear both masks
        cps_go = 1; cps_mask_wr = 1; cycle("R10");
        clear_ins();
        // R2: every request at once, data abort wins, link +8 (R5)
        {req_dabt, req_fiq, req_irq, req_pabt, req_und, req_svc, req_smc, req_bkpt} = '1;
        cur_pc = 32'h0000_0400; cycle("R2");
        check("R5", "dabt link", link_o, 32'h0000_0408);
        clear_ins();
        ret_sel = 2'b10; ret_go = 1; cycle("R9");
        clear_ins();
        // R2: FIQ over IRQ and prefetch abort; R6 masks
        req_fiq = 1; req_irq = 1; req_pabt = 1; cur_pc = 32'h0000_0800; cycle("R2");
        check("R6", "fiq masks", {24'h0, psr_o[7:6], 6'h0}, 32'h0000_00C0);
        clear_ins();
        ret_sel = 2'b01; ret_go = 1; cycle("R9");
        clear_ins();
        // R4: supervisor call in compressed state
        xstate = 1; req_svc = 1; cur_pc = 32'h0000_0A02; cycle("R4");
        check("R4", "svc half link", link_o, 32'h0000_0A04);
        clear_ins();
        ret_go = 1; cycle("R9");
        clear_ins();
        // R8: ignored requests
        xstate = 2; req_svc = 1; cycle("R8");
        xstate = 1; req_svc = 0; req_smc = 1; cycle("R8");
        clear_ins();
        // R7: monitor entry vector
        req_smc = 1; cur_pc = 32'h0000_0C00; cycle("R7");
        check("R7", "mon vector", redir_pc, 32'h0000_4000);
        clear_ins();
        // R11: compressed state keeps mode
        xstate = 1; cps_go = 1; cps_mode_wr = 1; cps_mode = 5'b11111;
        cps_mask_wr = 1; cps_irq_m = 1; cycle("R11");
        clear_ins();
        // R10: move to system, return is ignored there (R9)
        cps_go = 1; cps_mode_wr = 1; cps_mode = 5'b11111; cycle("R10");
        clear_ins();
        ret_go = 1; cycle("R9");
        clear_ins();
        cps_go = 1; cps_mode_wr = 1; cps_mode = 5'b10000; cycle("R10");
        clear_ins();
        cps_go = 1; cps_mode_wr = 1; cps_mode = 5'b10011; cps_mask_wr = 1; cycle("R10");
        check("R10", "user cps ignored", {27'h0, psr_o[4:0]}, 32'h0000_0010);
        clear_ins();
        // R5: breakpoint and undefined out of user mode
        req_bkpt = 1; cur_pc = 32'h0000_0E00; cycle("R5");
        clear_ins();
        req_und = 1; xstate = 2; cur_pc = 32'h0000_0E10; cycle("R4");
        clear_ins();
        // R12: return-from-exception with stalls
        rfe_go = 1; rfe_base = 32'h0000_3A40; cycle("R12");
        clear_ins();
        cycle("R12");
        check("R12", "addr beat0", mem_addr, 32'h0000_3A40);
        mem_ready = 1; cycle("R12");
        check("R12", "addr beat1", mem_addr, 32'h0000_3A44);
        mem_ready = 0; cycle("R12");
        mem_ready = 1; cycle("R12");
        check("R12", "rfe pc", redir_pc, mem_fn(32'h0000_3A40));
        clear_ins();
        // R13: operations ignored while busy, abort cancels
        cps_go = 1; cps_mask_wr = 1; cycle("R13");
        clear_ins();
        rfe_go = 1; rfe_base = 32'h0000_5100; cycle("R13");
        clear_ins();
        cps_go = 1; cps_mask_wr = 1; cps_irq_m = 1; mem_ready = 1; cycle("R13");
        clear_ins();
        req_dabt = 1; mem_ready = 1; cycle("R13");
        clear_ins();
        cycle("R13");
        check("R13", "cancelled req", 32'(mem_req), 32'h0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            int b;
            clear_ins();
            xstate = ($urandom % 4 == 0) ? 2'($urandom % 3) : 2'd0;
            cur_pc = $urandom & 32'hFFFF_FFFE;
            req_dabt = ($urandom % 60 == 0);
            req_fiq  = ($urandom % 30 == 0);
            req_irq  = ($urandom % 30 == 0);
            req_pabt = ($urandom % 60 == 0);
            req_und  = ($urandom % 60 == 0);
            req_svc  = ($urandom % 60 == 0);
            req_smc  = ($urandom % 60 == 0);
            req_bkpt = ($urandom % 60 == 0);
            r = $urandom % 12;
            if (r == 0) begin
                b = bidx(m_psr[4:0]);
                if (b < 0 || m_known[b]) begin ret_go = 1; ret_sel = 2'($urandom % 4); end
            end else if (r == 1) begin
                cps_go = 1; cps_mask_wr = 1'($urandom); cps_irq_m = 1'($urandom);
                cps_fiq_m = 1'($urandom); cps_mode_wr = 1'($urandom);
                cps_mode = mode_at($urandom % 8);
            end else if (r == 2) begin
                rfe_go = 1; rfe_base = $urandom & 32'hFFFF_FFFC;
            end
            mem_ready = ($urandom % 3 != 0);
            cycle("R2..R13 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule